// File: doc/BRIEF.md
# Excitation-Based Home-Run Deflection Arbiter

This block is the per-cycle port allocator of a bufferless mesh router. Up to four flits arrive in one cycle, one on each network input. Each flit carries a destination coordinate, the compass direction it is travelling in, and a one-bit "excited" mark. Every valid flit leaves with exactly one output assignment and an updated mark. Flits that have reached this node leave through the local port. All other flits share the four network outputs, and a flit that loses its preferred output is deflected to a free one. Because no flit is ever held back, the router needs no buffers.

Flits without the mark travel greedily: any output that shortens the distance is acceptable. A flit without the mark that gets deflected may become excited. The chance comes from a free-running linear feedback shift register, and the odds are set by a threshold input. An excited flit travels only along its row-then-column route and outranks every unmarked flit. If two excited flits want the same output, the one that keeps its heading wins. An excited flit that is deflected loses its mark. Results are registered, so they appear one clock after the inputs are sampled.

Top module: `homerun_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, all `out_valid` and `out_exc` bits are 0 and all `out_port` fields are 0. The random register restarts from 16'hACE1 on every reset.
- R2: A valid flit whose destination equals (`my_x`,`my_y`) is given the local port (code 4), and its `out_exc` is 0, regardless of what the other flits want.
- R3: Two valid flits in the same cycle are never given the same network port. Direction codes are N=0 (+y), E=1 (+x), S=2 (-y), W=3 (-x).
- R4: A flit without the mark is given a free output that shortens the distance. If both an x-axis and a y-axis output would do so, the x-axis output is tried first. Such a flit leaves with `out_exc` 0.
- R5: An excited flit whose route output is free takes it and stays excited. The route output is E or W while the x coordinates differ, and N or S once they match.
- R6: Excited flits are served before any flit without the mark, whatever their input indices.
- R7: Among excited flits, those whose route output equals their heading are served first. Within each of these two groups, the lower input index is served first.
- R8: An excited flit that does not get its route output is deflected and leaves with `out_exc` 0.
- R9: A flit without the mark that gets no shortening output leaves with `out_exc` 1 exactly when its draw is below `thresh`. The register steps every clock: next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. Port i's 8-bit draw has bit k equal to state bit (4i+k) mod 16, taken from the state in the sampling cycle.
- R10: Flits without the mark are served in rising input index order.
- R11: A deflected flit is given the lowest-numbered free network port.
- R12: An input with `in_valid` 0 yields `out_valid` 0 and `out_exc` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | XW | Column of this router |
| my_y | input | YW | Row of this router |
| thresh | input | TH_W | Excitation threshold compared with each draw |
| in_valid | input | 4 | Flit present on each input |
| in_dest_x | input | 4 x XW | Destination column per input |
| in_dest_y | input | 4 x YW | Destination row per input |
| in_head | input | 4 x 2 | Current travel direction per input |
| in_exc | input | 4 | Excited mark per input |
| out_valid | output | 4 | Registered: assignment present for each input |
| out_port | output | 4 x 3 | Registered assigned output (0..3 network, 4 local) |
| out_exc | output | 4 | Registered updated excited mark |

## Verification
The allocator holds almost no state, so a wrong ranking or a wrong port search shows up on the very next cycle: a port code differs from the reference, or two flits collide. The one hidden state, the random register, can only be seen through the marks that deflected unmarked flits receive. A wrong seed or wrong tap set would therefore change `out_exc` within the first few deflections. The bench makes such deflections happen in nearly every random cycle, at thresholds of 0, 255 and values in between.

// File: rtl/homerun_pkg.sv
package homerun_pkg;
  localparam int NP = 4;
  localparam int PCW = 3;

  typedef enum logic [2:0] {
    DIR_N     = 3'd0,
    DIR_E     = 3'd1,
    DIR_S     = 3'd2,
    DIR_W     = 3'd3,
    DIR_LOCAL = 3'd4
  } dir_e;

  // Search order for productive outputs: x axis before y axis.
  function automatic logic [1:0] greedy_order(input int k);
    case (k)
      0:       return 2'(DIR_E);
      1:       return 2'(DIR_W);
      2:       return 2'(DIR_N);
      default: return 2'(DIR_S);
    endcase
  endfunction
endpackage

// File: rtl/homerun_lfsr.sv
module homerun_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic [W-1:0] state_nxt;

  always_comb begin
    state_nxt = {state[W-2:0], ^(state & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/homerun_route.sv
module homerun_route #(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input  logic [XW-1:0] my_x,
  input  logic [YW-1:0] my_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output logic          at_dest,
  output logic [3:0]    prod,
  output logic [1:0]    xy_dir
);
  import homerun_pkg::*;

  logic go_e, go_w, go_n, go_s;

  always_comb begin
    go_e    = dst_x > my_x;
    go_w    = dst_x < my_x;
    go_n    = dst_y > my_y;
    go_s    = dst_y < my_y;
    at_dest = !(go_e || go_w || go_n || go_s);
    prod    = '0;
    prod[2'(DIR_E)] = go_e;
    prod[2'(DIR_W)] = go_w;
    prod[2'(DIR_N)] = go_n;
    prod[2'(DIR_S)] = go_s;
    if (go_e)      xy_dir = 2'(DIR_E);
    else if (go_w) xy_dir = 2'(DIR_W);
    else if (go_s) xy_dir = 2'(DIR_S);
    else           xy_dir = 2'(DIR_N);
  end
endmodule

// File: rtl/homerun_alloc.sv
module homerun_alloc (
  input  logic [homerun_pkg::NP-1:0]                          valid_i,
  input  logic [homerun_pkg::NP-1:0]                          exc_i,
  input  logic [homerun_pkg::NP-1:0][1:0]                     head_i,
  input  logic [homerun_pkg::NP-1:0]                          dest_i,
  input  logic [homerun_pkg::NP-1:0][3:0]                     prod_i,
  input  logic [homerun_pkg::NP-1:0][1:0]                     xy_i,
  input  logic [homerun_pkg::NP-1:0]                          hit_i,
  output logic [homerun_pkg::NP-1:0][homerun_pkg::PCW-1:0]    port_o,
  output logic [homerun_pkg::NP-1:0]                          exc_o
);
  import homerun_pkg::*;

  always_comb begin
    logic [3:0] taken;
    logic       elig;
    logic       got;
    logic [1:0] pick;
    logic [1:0] dd;
    taken  = '0;
    port_o = '0;
    exc_o  = '0;
    elig   = 1'b0;
    got    = 1'b0;
    pick   = 2'd0;
    dd     = 2'd0;
    for (int i = 0; i < NP; i++) begin
      if (valid_i[i] && dest_i[i]) port_o[i] = DIR_LOCAL;
    end
    // pass 0: excited going straight, 1: other excited, 2: normal
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < NP; i++) begin
        elig = valid_i[i] && !dest_i[i] &&
               ((p == 0 &&  exc_i[i] && (xy_i[i] == head_i[i])) ||
                (p == 1 &&  exc_i[i] && (xy_i[i] != head_i[i])) ||
                (p == 2 && !exc_i[i]));
        if (elig) begin
          got  = 1'b0;
          pick = 2'd0;
          if (exc_i[i]) begin
            if (!taken[xy_i[i]]) begin
              got  = 1'b1;
              pick = xy_i[i];
            end
          end else begin
            for (int k = 0; k < NP; k++) begin
              dd = greedy_order(k);
              if (!got && prod_i[i][dd] && !taken[dd]) begin
                got  = 1'b1;
                pick = dd;
              end
            end
          end
          if (got) begin
            exc_o[i] = exc_i[i];
          end else begin
            for (int d = 0; d < NP; d++) begin
              if (!got && !taken[d]) begin
                got  = 1'b1;
                pick = 2'(d);
              end
            end
            exc_o[i] = exc_i[i] ? 1'b0 : hit_i[i];
          end
          taken[pick] = 1'b1;
          port_o[i]   = {1'b0, pick};
        end
      end
    end
  end
endmodule

// File: rtl/homerun_arbiter.sv
module homerun_arbiter #(
  parameter int                XW     = 3,
  parameter int                YW     = 3,
  parameter int                LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
  parameter int                TH_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [XW-1:0]          my_x,
  input  logic [YW-1:0]          my_y,
  input  logic [TH_W-1:0]        thresh,
  input  logic [3:0]             in_valid,
  input  logic [3:0][XW-1:0]     in_dest_x,
  input  logic [3:0][YW-1:0]     in_dest_y,
  input  logic [3:0][1:0]        in_head,
  input  logic [3:0]             in_exc,
  output logic [3:0]             out_valid,
  output logic [3:0][2:0]        out_port,
  output logic [3:0]             out_exc
);
  import homerun_pkg::*;

  localparam int STEP = LFSR_W / NP;

  logic [LFSR_W-1:0]        rnd;
  logic [NP-1:0]            at_dest;
  logic [NP-1:0][3:0]       prod;
  logic [NP-1:0][1:0]       xy;
  logic [NP-1:0][TH_W-1:0]  draw;
  logic [NP-1:0]            hit;
  logic [NP-1:0][PCW-1:0]   port_nxt;
  logic [NP-1:0]            exc_nxt;
  logic                     was_run;

  homerun_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (rnd)
  );

  for (genvar i = 0; i < NP; i++) begin : g_port
    homerun_route #(.XW(XW), .YW(YW)) u_route (
      .my_x    (my_x),
      .my_y    (my_y),
      .dst_x   (in_dest_x[i]),
      .dst_y   (in_dest_y[i]),
      .at_dest (at_dest[i]),
      .prod    (prod[i]),
      .xy_dir  (xy[i])
    );
    for (genvar k = 0; k < TH_W; k++) begin : g_bit
      assign draw[i][k] = rnd[(i * STEP + k) % LFSR_W];
    end
    assign hit[i] = draw[i] < thresh;
  end

  homerun_alloc u_alloc (
    .valid_i (in_valid),
    .exc_i   (in_exc),
    .head_i  (in_head),
    .dest_i  (at_dest),
    .prod_i  (prod),
    .xy_i    (xy),
    .hit_i   (hit),
    .port_o  (port_nxt),
    .exc_o   (exc_nxt)
  );

  logic [NP-1:0]          valid_d;
  logic [NP-1:0][PCW-1:0] port_d;
  logic [NP-1:0]          exc_d;

  always_comb begin
    valid_d = in_valid;
    port_d  = port_nxt;
    exc_d   = exc_nxt & in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_port  <= '0;
      out_exc   <= '0;
      was_run   <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_port  <= port_d;
      out_exc   <= exc_d;
      was_run   <= 1'b1;
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_chk
    assert_eject_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
      was_run && $past(in_valid[i] && at_dest[i]) |-> out_port[i] == DIR_LOCAL && !out_exc[i]);
    assert_excited_on_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
      was_run && out_valid[i] && out_exc[i] && $past(in_exc[i] && !at_dest[i])
      |-> out_port[i] == {1'b0, $past(xy[i])});
    assert_excited_revert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      was_run && $past(in_valid[i] && in_exc[i] && !at_dest[i]) &&
      (out_port[i] != {1'b0, $past(xy[i])}) |-> !out_exc[i]);
    assert_zero_thresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
      was_run && $past(in_valid[i] && !in_exc[i] && thresh == '0) |-> !out_exc[i]);
    assert_idle_input_R12: assert property (@(posedge clk) disable iff (!rst_n)
      was_run && !$past(in_valid[i]) |-> !out_valid[i] && !out_exc[i]);
    for (genvar j = i + 1; j < NP; j++) begin : g_pair
      assert_distinct_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[i] && out_valid[j] && out_port[i] != DIR_LOCAL |-> out_port[i] != out_port[j]);
    end
  end
endmodule

// File: tb/test_homerun_arbiter.sv
module test_homerun_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int MX = 3;
  localparam int MY = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [2:0]      my_x, my_y;
  logic [7:0]      thresh;
  logic [3:0]      in_valid;
  logic [3:0][2:0] in_dest_x, in_dest_y;
  logic [3:0][1:0] in_head;
  logic [3:0]      in_exc;
  logic [3:0]      out_valid;
  logic [3:0][2:0] out_port;
  logic [3:0]      out_exc;

  int checks = 0;
  int errors = 0;
  logic [15:0] mlfsr;
  int exp_v[NP], exp_p[NP], exp_e[NP];

  always #(CLK_PERIOD / 2) clk = ~clk;

  homerun_arbiter i_homerun_arbiter (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y), .thresh(thresh),
    .in_valid(in_valid), .in_dest_x(in_dest_x), .in_dest_y(in_dest_y),
    .in_head(in_head), .in_exc(in_exc),
    .out_valid(out_valid), .out_port(out_port), .out_exc(out_exc)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic put(input int i, input int x, input int y, input int h, input int e);
    in_valid[i]  = 1'b1;
    in_dest_x[i] = 3'(x);
    in_dest_y[i] = 3'(y);
    in_head[i]   = 2'(h);
    in_exc[i]    = 1'(e);
  endtask

  task automatic clear();
    in_valid = '0; in_dest_x = '0; in_dest_y = '0; in_head = '0; in_exc = '0;
  endtask

  // Home-run output: x first, then y. 0=N 1=E 2=S 3=W
  function automatic int home_dir(int x, int y);
    if (x > MX) return 1;
    if (x < MX) return 3;
    if (y < MY) return 2;
    return 0;
  endfunction

  function automatic int draw_of(int i);
    int v = 0;
    for (int k = 0; k < 8; k++) v |= int'(mlfsr[(4 * i + k) % 16]) << k;
    return v;
  endfunction

  task automatic predict();
    int order[$];
    bit used[4];
    for (int d = 0; d < 4; d++) used[d] = 0;
    for (int i = 0; i < NP; i++) begin
      exp_v[i] = in_valid[i]; exp_p[i] = 0; exp_e[i] = 0;
      if (in_valid[i] && in_dest_x[i] == MX && in_dest_y[i] == MY) exp_p[i] = 4;
    end
    for (int grp = 0; grp < 3; grp++)
      for (int i = 0; i < NP; i++) begin
        bit home = (in_dest_x[i] == MX && in_dest_y[i] == MY);
        bit straight = home_dir(in_dest_x[i], in_dest_y[i]) == int'(in_head[i]);
        if (in_valid[i] && !home) begin
          if (grp == 0 && in_exc[i] && straight) order.push_back(i);
          if (grp == 1 && in_exc[i] && !straight) order.push_back(i);
          if (grp == 2 && !in_exc[i]) order.push_back(i);
        end
      end
    foreach (order[n]) begin
      int i = order[n];
      int x = in_dest_x[i];
      int y = in_dest_y[i];
      int want = -1;
      if (in_exc[i]) begin
        if (!used[home_dir(x, y)]) want = home_dir(x, y);
      end else begin
        if (x > MX && !used[1]) want = 1;
        else if (x < MX && !used[3]) want = 3;
        else if (y > MY && !used[0]) want = 0;
        else if (y < MY && !used[2]) want = 2;
      end
      if (want >= 0) exp_e[i] = in_exc[i];
      else begin
        for (int d = 3; d >= 0; d--) if (!used[d]) want = d;
        exp_e[i] = in_exc[i] ? 0 : int'(draw_of(i) < int'(thresh));
      end
      used[want] = 1;
      exp_p[i] = want;
    end
    mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
  endtask

  task automatic run_cycle(input string tag);
    predict();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      chk(tag, $sformatf("valid[%0d]", i), int'(out_valid[i]), exp_v[i]);
      if (exp_v[i] != 0) begin
        chk(tag, $sformatf("port[%0d]", i), int'(out_port[i]), exp_p[i]);
        chk(tag, $sformatf("exc[%0d]", i), int'(out_exc[i]), exp_e[i]);
      end else chk(tag, $sformatf("exc[%0d] idle", i), int'(out_exc[i]), 0);
      for (int j = i + 1; j < NP; j++)
        if (out_valid[i] && out_valid[j] && out_port[i] != 3'd4 && out_port[i] == out_port[j])
          chk("R3", $sformatf("port clash %0d/%0d", i, j), int'(out_port[j]), -1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; my_x = 3'(MX); my_y = 3'(MY); thresh = '0;
    clear();
    put(0, 6, 3, 1, 1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      chk("R1", "reset valid", int'(out_valid[i]), 0);
      chk("R1", "reset port", int'(out_port[i]), 0);
      chk("R1", "reset exc", int'(out_exc[i]), 0);
    end
    clear();
    rst_n = 1'b1;
    mlfsr = 16'hACE1;

    put(0, 3, 3, 0, 1); put(2, 3, 3, 1, 0); put(1, 6, 3, 1, 0);
    run_cycle("R2");
    clear(); put(2, 5, 1, 0, 0); put(3, 3, 6, 0, 0);
    run_cycle("R4");
    clear(); put(0, 6, 3, 1, 0); put(1, 6, 3, 1, 0); put(2, 6, 3, 1, 0);
    run_cycle("R10 R11");
    clear(); put(0, 6, 3, 1, 0); put(3, 6, 3, 0, 1);
    run_cycle("R6");
    clear(); put(0, 6, 3, 0, 1); put(1, 6, 5, 1, 1);
    run_cycle("R7 R8");
    clear(); put(2, 6, 0, 1, 1); put(3, 6, 3, 1, 1);
    run_cycle("R7");
    clear(); put(1, 3, 0, 1, 1); put(0, 5, 5, 1, 1);
    run_cycle("R5");
    clear();
    run_cycle("R12");
    thresh = 8'd255;
    for (int n = 0; n < 20; n++) begin
      clear(); for (int i = 0; i < NP; i++) put(i, 7, 3, 1, 0);
      run_cycle("R9");
    end
    thresh = 8'd100;
    for (int n = 0; n < 20; n++) begin
      clear(); for (int i = 0; i < NP; i++) put(i, 0, 3, 3, 0);
      run_cycle("R9");
    end
    for (int n = 0; n < 400; n++) begin
      thresh = 8'($urandom_range(0, 255));
      for (int i = 0; i < NP; i++) begin
        in_valid[i]  = 1'($urandom_range(0, 7) != 0);
        in_dest_x[i] = 3'($urandom_range(1, 5));
        in_dest_y[i] = 3'($urandom_range(1, 5));
        in_head[i]   = 2'($urandom_range(0, 3));
        in_exc[i]    = 1'($urandom_range(0, 1));
      end
      run_cycle("R3 R4 R6 R7 R11 random");
    end
    clear();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mlfsr = 16'hACE1;
    thresh = 8'd200;
    for (int n = 0; n < 8; n++) begin
      clear(); for (int i = 0; i < NP; i++) put(i, 3, 7, 1, 0);
      run_cycle("R1 reseed");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule